// File: doc/BRIEF.md
# Coil-Driver Configuration Port over I2C

This block is the two-wire configuration front end of a lens-focus coil driver. An external host reaches it as an I2C target at a fixed 7-bit address. The host sends a register index, then any number of data bytes, or it switches to reading with a repeated START. The block holds a few byte-wide settings: an enable bit, a 10-bit coil-current setpoint split over two bytes, the output-stage mode fields and the spring resonance setting. It also shows a set of live fault flags that other logic on the chip raises.

SCL and SDA arrive already synchronised to the system clock. Each line passes through a majority-free glitch filter before START, STOP and bit edges are decoded. The block pulls SDA low for ACKs and for zero bits on reads, and never drives it high. The index advances after every byte written or read, so bursts walk through consecutive registers. The current setpoint reaches the driver only when its low byte lands, so the driver never sees half an update.

Top module: `vcm_i2c_regs`

## Requirements
- R1: The block acknowledges only an address byte whose upper seven bits equal SLAVE_ADDR (default 7'b0001110, the group code 0001 then unit code 110), with bit 0 giving the direction (1 = read). Any other address gets no ACK, and the rest of that transfer changes nothing. SDA is only ever pulled low (sdaOe = 1), never driven high.
- R2: In a write transfer, the byte after the address loads the register index and is acknowledged. A STOP returns the block to idle.
- R3: Every data byte written is acknowledged, stored at the current index, and the index then steps by one, so several bytes may follow in one transfer.
- R4: A read returns the byte at the current index, MSB first, then steps the index. Reading continues while the host acknowledges and ends at the host's NACK.
- R5: After reset the registers read 0x02 at index 0x02 (bit 1 ring-compensation enable = 1), 0x00 at 0x03, 0x04 and 0x06, and 0x83 at 0x07. Unused bits read 0.
- R6: Writing a byte with bit 0 set to index 0x02 returns every register to its reset value. Bit 0 always reads 0. Otherwise bit 1 of that byte sets the enable.
- R7: The coil setpoint output is {bits [1:0] last written to 0x03, byte written to 0x04}. It changes only when 0x04 is written. A write to 0x03 alone leaves the output unchanged. Index 0x03 reads back the staged high bits.
- R8: Index 0x06 holds bits [4:2] PWM frequency code, bit 1 linear stage (1 = linear, 0 = PWM) and bit 0 settle mode. Bits [7:5] read 0.
- R9: Index 0x05 reads {3'b000, statusFlags[4:0]} live, with flag order thermal, coil short, coil open, undervoltage, overcurrent from bit 4 down. Writes to it are ignored.
- R10: Indices other than 0x02..0x07 read 0x00. Writes to them are ignored, but the index still steps.
- R11: A pulse on SCL or SDA shorter than FILT_LEN system clocks is ignored. A pulse on SDA while SCL is high does not break a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Synchronised bus clock level |
| sdaIn | input | 1 | Synchronised bus data level |
| statusFlags | input | 5 | Live fault flags shown at index 0x05 |
| sdaOe | output | 1 | 1 = pull SDA low |
| ringEn | output | 1 | Ring compensation enable |
| coilCurrent | output | 10 | Committed coil current setpoint |
| pwmFreqSel | output | 3 | PWM frequency code |
| linearMode | output | 1 | 1 = linear stage, 0 = PWM |
| settleMode | output | 1 | Settle time selection |
| resFreq | output | 8 | Resonance frequency setting |

## Verification
The bench builds the block with FILT_LEN = 4 and the default address. A filter this long makes a three-cycle SDA pulse in the middle of a high SCL phase a real test of R11: without the filter, that pulse would be decoded as a START followed by a STOP. The bus quarter period of ten system clocks leaves room for the filter and decode latency inside each SCL phase. It also keeps the burst, repeated-START, wrong-address and soft-reset sequences short enough that the outputs can be compared to the model on every clock.

// File: rtl/vcm_i2c_pkg.sv
package vcm_i2c_pkg;

  typedef struct packed {
    logic       loadPtr;
    logic       writeByte;
    logic       readAdv;
    logic [7:0] data;
  } busStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_SUB, S_SUB_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_MACK
  } busState_t;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_CUR_HI = 8'h03;
  localparam logic [7:0] IDX_CUR_LO = 8'h04;
  localparam logic [7:0] IDX_STATUS = 8'h05;
  localparam logic [7:0] IDX_MODE   = 8'h06;
  localparam logic [7:0] IDX_FREQ   = 8'h07;
  localparam logic [7:0] FREQ_RST   = 8'h83;

endpackage

// File: rtl/pin_filter.sv
module pin_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  output logic filt
);
  logic [LEN-1:0] hist;

  // The output follows only after LEN equal samples in a row.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist <= '1;
      filt <= 1'b1;
    end else begin
      hist <= {hist[LEN-2:0], raw};
      if (&hist)       filt <= 1'b1;
      else if (~|hist) filt <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import vcm_i2c_pkg::*;
#(
  parameter int         FILT_LEN   = 3,
  parameter logic [6:0] SLAVE_ADDR = 7'h0E
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output busStrobe_t strb,
  output logic       sdaOe
);
  logic sclF, sdaF, sclPrev, sdaPrev;
  logic [1:0] rawPins, filtPins;
  assign rawPins = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    pin_filter #(.LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .raw(rawPins[g]), .filt(filtPins[g])
    );
  end
  assign {sclF, sdaF} = filtPins;

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shReg;
  logic       rdMode, hostNack;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;  sdaPrev <= 1'b1;
      state <= S_IDLE;  bitCnt <= '0;  shReg <= '0;
      rdMode <= 1'b0;   hostNack <= 1'b0;  strb <= '0;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
      strb.loadPtr   <= 1'b0;
      strb.writeByte <= 1'b0;
      strb.readAdv   <= 1'b0;
      if (startDet) begin
        state  <= S_ADDR;
        bitCnt <= '0;
      end else if (stopDet) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_ADDR, S_SUB, S_WR: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaF};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == S_ADDR) begin
                if (shReg[7:1] == SLAVE_ADDR) begin
                  rdMode <= shReg[0];
                  state  <= S_ADDR_ACK;
                end else begin
                  state <= S_IDLE;
                end
              end else if (state == S_SUB) begin
                strb.loadPtr <= 1'b1;
                strb.data    <= shReg;
                state        <= S_SUB_ACK;
              end else begin
                strb.writeByte <= 1'b1;
                strb.data      <= shReg;
                state          <= S_WR_ACK;
              end
            end
          end
          S_ADDR_ACK: if (sclFall) begin
            if (rdMode) begin
              shReg        <= rdData;
              strb.readAdv <= 1'b1;
              state        <= S_RD;
            end else begin
              state <= S_SUB;
            end
          end
          S_SUB_ACK, S_WR_ACK: if (sclFall) state <= S_WR;
          S_RD: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              bitCnt <= '0;
              state  <= S_RD_MACK;
            end else begin
              shReg  <= {shReg[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
          S_RD_MACK: begin
            if (sclRise) hostNack <= sdaF;
            else if (sclFall) begin
              if (hostNack) state <= S_IDLE;
              else begin
                shReg        <= rdData;
                strb.readAdv <= 1'b1;
                state        <= S_RD;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    sdaOe = 1'b0;
    if (state == S_ADDR_ACK || state == S_SUB_ACK || state == S_WR_ACK) sdaOe = 1'b1;
    else if (state == S_RD) sdaOe = ~shReg[7];
  end

  // R3: at most one pointer action per cycle
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPtr, strb.writeByte, strb.readAdv}));
  // R1: an idle target never pulls the line
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);
  // R2: STOP returns to idle
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> (state == S_IDLE));
  // R1: START always restarts address reception
  p_start_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_ADDR && bitCnt == 4'd0));
endmodule

// File: rtl/coil_regfile.sv
module coil_regfile
  import vcm_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busStrobe_t strb,
  input  logic [4:0] statusFlags,
  output logic [7:0] rdData,
  output logic       ringEn,
  output logic [9:0] coilCurrent,
  output logic [2:0] pwmFreqSel,
  output logic       linearMode,
  output logic       settleMode,
  output logic [7:0] resFreq
);
  logic [7:0] ptr;
  logic [1:0] curHiStage;
  logic [4:0] modeReg;
  logic       softRst;

  assign softRst = strb.writeByte && (ptr == IDX_CTRL) && strb.data[0];

  always_ff @(posedge clk) begin
    if (!rstN)              ptr <= '0;
    else if (strb.loadPtr)  ptr <= strb.data;
    else if (strb.writeByte || strb.readAdv) ptr <= ptr + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      ringEn      <= 1'b1;
      curHiStage  <= '0;
      coilCurrent <= '0;
      modeReg     <= '0;
      resFreq     <= FREQ_RST;
    end else if (strb.writeByte) begin
      case (ptr)
        IDX_CTRL:   ringEn      <= strb.data[1];
        IDX_CUR_HI: curHiStage  <= strb.data[1:0];
        IDX_CUR_LO: coilCurrent <= {curHiStage, strb.data};
        IDX_MODE:   modeReg     <= strb.data[4:0];
        IDX_FREQ:   resFreq     <= strb.data;
        default: ;
      endcase
    end
  end

  assign pwmFreqSel = modeReg[4:2];
  assign linearMode = modeReg[1];
  assign settleMode = modeReg[0];

  always_comb begin
    case (ptr)
      IDX_CTRL:   rdData = {6'b0, ringEn, 1'b0};
      IDX_CUR_HI: rdData = {6'b0, curHiStage};
      IDX_CUR_LO: rdData = coilCurrent[7:0];
      IDX_STATUS: rdData = {3'b0, statusFlags};
      IDX_MODE:   rdData = {3'b0, modeReg};
      IDX_FREQ:   rdData = resFreq;
      default:    rdData = 8'h00;
    endcase
  end

  // R6: a soft reset leaves every field at its reset value
  p_soft_defaults_r6: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (ringEn && coilCurrent == 10'd0 && modeReg == 5'd0 && resFreq == FREQ_RST));
  // R7: a high-byte write never moves the setpoint
  p_hi_no_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeByte && ptr == IDX_CUR_HI) |=> $stable(coilCurrent));
  // R3, R10: every written byte steps the index
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> (ptr == $past(ptr) + 8'd1));
endmodule

// File: rtl/vcm_i2c_regs.sv
module vcm_i2c_regs
  import vcm_i2c_pkg::*;
#(
  parameter int         FILT_LEN   = 3,
  parameter logic [6:0] SLAVE_ADDR = 7'h0E
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [4:0] statusFlags,
  output logic       sdaOe,
  output logic       ringEn,
  output logic [9:0] coilCurrent,
  output logic [2:0] pwmFreqSel,
  output logic       linearMode,
  output logic       settleMode,
  output logic [7:0] resFreq
);
  busStrobe_t strb;
  logic [7:0] rdData;

  i2c_bus_ctrl #(.FILT_LEN(FILT_LEN), .SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .strb(strb), .sdaOe(sdaOe)
  );

  coil_regfile u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .statusFlags(statusFlags),
    .rdData(rdData), .ringEn(ringEn), .coilCurrent(coilCurrent),
    .pwmFreqSel(pwmFreqSel), .linearMode(linearMode),
    .settleMode(settleMode), .resFreq(resFreq)
  );
endmodule

// File: tb/tb_vcm_i2c_regs.sv
module tb_vcm_i2c_regs;
  localparam int FLEN = 4;
  localparam int Q    = 10;
  localparam logic [6:0] ADDR = 7'h0E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [4:0] flags = 5'b10110;
  logic sdaOe, ringEn, linearMode, settleMode;
  logic [9:0] coilCurrent;
  logic [2:0] pwmFreqSel;
  logic [7:0] resFreq;
  wire sdaBus = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  vcm_i2c_regs #(.FILT_LEN(FLEN), .SLAVE_ADDR(ADDR)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .statusFlags(flags), .sdaOe(sdaOe), .ringEn(ringEn),
    .coilCurrent(coilCurrent), .pwmFreqSel(pwmFreqSel),
    .linearMode(linearMode), .settleMode(settleMode), .resFreq(resFreq)
  );

  int checks = 0, errors = 0;
  bit done = 0, cmpEn = 0;

  // behavioural reference state
  logic       mRing = 1'b1;
  logic [1:0] mHi = '0;
  logic [9:0] mCur = '0;
  logic [4:0] mMode = '0;
  logic [7:0] mFreq = 8'h83;
  int         mPtr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mRead(input int a);
    case (a)
      2: return {6'b0, mRing, 1'b0};
      3: return {6'b0, mHi};
      4: return mCur[7:0];
      5: return {3'b0, flags};
      6: return {3'b0, mMode};
      7: return mFreq;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mWrite(input logic [7:0] d);
    case (mPtr)
      2: if (d[0]) begin
           mRing = 1'b1; mHi = '0; mCur = '0; mMode = '0; mFreq = 8'h83;
         end else mRing = d[1];
      3: mHi = d[1:0];
      4: mCur = {mHi, d};
      6: mMode = d[4:0];
      7: mFreq = d;
      default: ;
    endcase
    mPtr = (mPtr + 1) % 256;
  endtask

  // compare every clock against the model
  always @(negedge clk) begin
    if (rstN && cmpEn) begin
      chk(ringEn == mRing, "R6 ringEn", ringEn, mRing);
      chk(coilCurrent == mCur, "R7 coilCurrent", coilCurrent, mCur);
      chk({pwmFreqSel, linearMode, settleMode} == mMode, "R8 mode fields",
          {pwmFreqSel, linearMode, settleMode}, mMode);
      chk(resFreq == mFreq, "R5 resFreq", resFreq, mFreq);
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit isData,
                          input bit glitch, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ();
      if (glitch && i == 7) begin
        sdaM = 1'b0;
        repeat (FLEN - 1) @(negedge clk);
        sdaM = 1'b1;
      end
      waitQ();
      if (i == 0 && isData) cmpEn = 0;
      sclM = 1'b0; waitQ();
    end
    if (isData) begin mWrite(b); cmpEn = 1; end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    chk(sdaBus == !expAck, tag, sdaBus, !expAck);
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic readByte(input bit last);
    logic [7:0] got;
    logic [7:0] exp;
    string tag;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
      got[i] = sdaBus;
      waitQ(); sclM = 1'b0; waitQ();
    end
    exp = mRead(mPtr);
    if (mPtr == 5) tag = "R9 status read";
    else if (mPtr < 2 || mPtr > 7) tag = "R10 unmapped read";
    else tag = "R4 register read";
    chk(got == exp, tag, got, exp);
    mPtr = (mPtr + 1) % 256;
    sdaM = last; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic wrRegs(input logic [7:0] sub, input int n, input logic [7:0] d [4],
                        input bit glitch);
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R1 address ack");
    sendByte(sub, 1, 0, 0, "R2 index ack");
    mPtr = sub;
    for (int k = 0; k < n; k++) sendByte(d[k], 1, 1, glitch, "R3 data ack");
    busStop();
  endtask

  task automatic rdRegs(input logic [7:0] sub, input int n);
    busStart();
    sendByte({ADDR, 1'b0}, 1, 0, 0, "R1 address ack");
    sendByte(sub, 1, 0, 0, "R2 index ack");
    mPtr = sub;
    busStart();
    sendByte({ADDR, 1'b1}, 1, 0, 0, "R1 read address ack");
    for (int k = 0; k < n; k++) readByte(k == n - 1);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R5: reset state at the ports
    chk(ringEn == 1'b1, "R5 reset ringEn", ringEn, 1);
    chk(coilCurrent == 10'd0, "R5 reset coilCurrent", coilCurrent, 0);
    chk(resFreq == 8'h83, "R5 reset resFreq", resFreq, 8'h83);
    chk(sdaOe == 1'b0, "R1 reset release", sdaOe, 0);
    cmpEn = 1;
    waitQ();

    // R4, R5, R9, R10: burst read of indices 0..8 after reset
    rdRegs(8'h00, 9);

    // R8: mode fields, upper bits read 0
    wrRegs(8'h06, 1, '{8'hFF, 0, 0, 0}, 0);
    rdRegs(8'h06, 1);
    wrRegs(8'h06, 1, '{8'h0D, 0, 0, 0}, 0);
    chk(pwmFreqSel == 3'b011 && !linearMode && settleMode, "R8 field split",
        {pwmFreqSel, linearMode, settleMode}, 5'b01101);

    // R7: high byte alone is staged, low byte commits
    wrRegs(8'h03, 1, '{8'h02, 0, 0, 0}, 0);
    chk(coilCurrent == 10'd0, "R7 high byte staged only", coilCurrent, 0);
    wrRegs(8'h03, 2, '{8'h01, 8'hAB, 0, 0}, 0);
    chk(coilCurrent == 10'h1AB, "R7 burst commit", coilCurrent, 10'h1AB);
    wrRegs(8'h04, 1, '{8'hCD, 0, 0, 0}, 0);
    chk(coilCurrent == 10'h1CD, "R7 low byte reuses staged high", coilCurrent, 10'h1CD);
    rdRegs(8'h03, 2);

    // R10: unmapped writes ignored, index still steps to 0x02
    wrRegs(8'h00, 3, '{8'h5A, 8'hA5, 8'h00, 0}, 0);
    chk(ringEn == 1'b0, "R10 index stepped past unmapped", ringEn, 0);
    rdRegs(8'h00, 3);

    // R9: status is read-only and live
    wrRegs(8'h05, 1, '{8'hFF, 0, 0, 0}, 0);
    rdRegs(8'h05, 1);
    flags = 5'b01001;
    rdRegs(8'h05, 1);

    // R1: foreign address is not acknowledged and changes nothing
    busStart();
    sendByte({7'h0F, 1'b0}, 0, 0, 0, "R1 foreign address no ack");
    sendByte(8'h07, 0, 0, 0, "R1 ignored index");
    sendByte(8'h11, 0, 0, 0, "R1 ignored data");
    busStop();
    chk(resFreq == 8'h83, "R1 foreign write ignored", resFreq, 8'h83);

    // R11: SDA pulse shorter than the filter during SCL high
    wrRegs(8'h07, 1, '{8'hC4, 0, 0, 0}, 1);
    chk(resFreq == 8'hC4, "R11 glitch ignored", resFreq, 8'hC4);

    // R6: soft reset returns everything to defaults
    wrRegs(8'h02, 1, '{8'h01, 0, 0, 0}, 0);
    chk(ringEn && coilCurrent == 0 && resFreq == 8'h83 && pwmFreqSel == 0,
        "R6 soft reset", {ringEn, resFreq}, {1'b1, 8'h83});
    rdRegs(8'h02, 1);

    // R3: burst write over mode and frequency, then burst read
    wrRegs(8'h06, 2, '{8'h09, 8'h3C, 0, 0}, 0);
    rdRegs(8'h03, 5);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule